// File: doc/BRIEF.md
# Single-Level Context Shadow Store

This block keeps one saved copy of three core processor registers: the 5-bit status word, the 8-bit working register and the 4-bit bank selector. Any interrupt entry, whatever its source or priority, loads the copy. A call that asks for the fast option also loads it. A return that asks for the fast option, from an interrupt or from a subroutine, drives the saved copy back, so the core can restore its context in a single cycle without pushing anything to memory.

There is only one level, and every capture event shares it. If a high-priority interrupt arrives while a low-priority handler is running, it silently replaces what the low-priority entry saved. The copy has no software read or write path. Its only way out is through the restore outputs, which always present the held values, qualified by a restore-enable strobe.

A small controller has two named states. `SH_EMPTY` means nothing has been captured since reset. `SH_HELD` means at least one capture has happened. The transition `EMPTY->HELD` is taken on the first capture. `HELD->HELD` is taken on every later capture, which overwrites the copy. Every other cycle holds the current state. No event returns the controller to `SH_EMPTY` except reset.

Top module: `shadow_ctx_store`

## Requirements
- R1: After reset, all three restore outputs read zero and `restore_en_o` is low.
- R2: When `vec_take_i` is high at a rising clock edge, the status, working and bank inputs are captured, and from the next cycle they appear on `status_o`, `wreg_o` and `bank_o`.
- R3: When `call_fast_i` is high at a rising clock edge, the three inputs are captured in the same way as in R2.
- R4: While `ret_fast_i` is high and no capture strobe is high, `restore_en_o` is high in that same cycle, and the restore outputs carry the values saved by the latest capture.
- R5: While `ret_fast_i` is low (a return without the fast option, or no return at all), `restore_en_o` stays low. With no capture strobe, the held values do not change whatever the live inputs do.
- R6: When a capture strobe and `ret_fast_i` are high in the same cycle, `restore_en_o` stays low and the capture takes effect.
- R7: A capture while a copy is already held (for example, a nested interrupt) replaces the copy. The earlier values are lost.
- R8: A fast return does not consume the copy: repeated fast returns keep presenting the same saved values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 5 | Live status register value |
| wreg_i | input | 8 | Live working register value |
| bank_i | input | 4 | Live bank select value |
| vec_take_i | input | 1 | Interrupt vectoring strobe (any priority) |
| call_fast_i | input | 1 | Call with fast save option |
| ret_fast_i | input | 1 | Return (from interrupt or call) with fast restore option |
| status_o | output | 5 | Saved status value for restore |
| wreg_o | output | 8 | Saved working register value for restore |
| bank_o | output | 4 | Saved bank select value for restore |
| restore_en_o | output | 1 | Load the saved values into the live registers this cycle |

## Verification
The bench aims at a capture and a fast return in the same cycle. A design that gave priority to the return would pulse restore-enable and restore stale values (R6). It also covers back-to-back captures standing in for a nested interrupt, and catches a design that refused to overwrite or that kept an older copy (R7). Repeated fast returns with no capture between them expose a design that clears or shifts the copy on restore (R8). Random live-input changes with no strobes catch a design that leaks the live values into the copy (R5).

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int STAT_W = 5;
    localparam int WREG_W = 8;
    localparam int BANK_W = 4;

    typedef enum logic [0:0] {
        SH_EMPTY = 1'b0,
        SH_HELD  = 1'b1
    } sh_state_e;
endpackage

// File: rtl/shadow_slot.sv
module shadow_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= d;
    end

    assign q = held_q;

    AST_SLOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d))); // R2
    AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R5
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
    import shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vec_take_i,
    input  logic      call_fast_i,
    input  logic      ret_fast_i,
    output logic      capture_o,
    output logic      restore_en_o,
    output sh_state_e state_o
);
    sh_state_e state_q, state_d;
    logic      cap;

    assign cap = vec_take_i | call_fast_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        capture_o    = 1'b0;
        restore_en_o = 1'b0;
        unique case (state_q)
            SH_EMPTY: begin
                if (cap) begin
                    capture_o = 1'b1;
                    state_d   = SH_HELD;
                end else if (ret_fast_i) begin
                    restore_en_o = 1'b1;
                end
            end
            SH_HELD: begin
                if (cap) begin
                    capture_o = 1'b1;
                    state_d   = SH_HELD;
                end else if (ret_fast_i) begin
                    restore_en_o = 1'b1;
                end
            end
            default: state_d = SH_EMPTY;
        endcase
    end

    assign state_o = state_q;

    AST_CAP_BLOCKS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take_i || call_fast_i) |-> !restore_en_o); // R6
    AST_RESTORE_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en_o |-> ret_fast_i); // R5
    AST_HELD_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> (state_q == SH_HELD)); // R7
endmodule

// File: rtl/shadow_ctx_store.sv
module shadow_ctx_store
    import shadow_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int WW = WREG_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] status_i,
    input  logic [WW-1:0] wreg_i,
    input  logic [BW-1:0] bank_i,
    input  logic          vec_take_i,
    input  logic          call_fast_i,
    input  logic          ret_fast_i,
    output logic [SW-1:0] status_o,
    output logic [WW-1:0] wreg_o,
    output logic [BW-1:0] bank_o,
    output logic          restore_en_o
);
    logic      capture;
    sh_state_e state;

    shadow_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_take_i   (vec_take_i),
        .call_fast_i  (call_fast_i),
        .ret_fast_i   (ret_fast_i),
        .capture_o    (capture),
        .restore_en_o (restore_en_o),
        .state_o      (state)
    );

    shadow_slot #(.W(SW)) u_status (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(status_i), .q(status_o));
    shadow_slot #(.W(WW)) u_wreg (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(wreg_i), .q(wreg_o));
    shadow_slot #(.W(BW)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(capture), .d(bank_i), .q(bank_o));

    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_EMPTY) |-> (status_o == '0 && wreg_o == '0 && bank_o == '0)); // R1
    AST_RESTORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_en_o && !capture) |=> ($stable(wreg_o) && $stable(status_o) && $stable(bank_o))); // R8
endmodule

// File: tb/shadow_ctx_store_test.sv
`timescale 1ns/100ps
module shadow_ctx_store_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] status_i = '0;
    logic [7:0] wreg_i = '0;
    logic [3:0] bank_i = '0;
    logic       vec_take_i = 1'b0, call_fast_i = 1'b0, ret_fast_i = 1'b0;
    logic [4:0] status_o;
    logic [7:0] wreg_o;
    logic [3:0] bank_o;
    logic       restore_en_o;

    int checks = 0;
    int fails = 0;
    logic [16:0] model = '0;
    logic        held = 1'b0;

    always #2.5 clk = ~clk;

    shadow_ctx_store uut (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .wreg_i(wreg_i), .bank_i(bank_i),
        .vec_take_i(vec_take_i), .call_fast_i(call_fast_i), .ret_fast_i(ret_fast_i),
        .status_o(status_o), .wreg_o(wreg_o), .bank_o(bank_o), .restore_en_o(restore_en_o)
    );

    function automatic logic exp_en(input logic v, input logic c, input logic r);
        return r && !(v || c);
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, check combinational and held outputs, then advance one edge.
    task automatic step(input logic v, input logic c, input logic r, input string vtag);
        string etag;
        vec_take_i = v; call_fast_i = c; ret_fast_i = r;
        #1;
        etag = (v || c) ? "R6" : (r ? "R4" : "R5");
        chk(etag, {16'd0, restore_en_o}, {16'd0, exp_en(v, c, r)});
        chk(vtag, {status_o, wreg_o, bank_o}, model);
        @(posedge clk);
        if (v || c) begin
            model = {status_i, wreg_i, bank_i};
            held  = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic live(input logic [16:0] x);
        {status_i, wreg_i, bank_i} = x;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        #1;
        chk("R1", {status_o, wreg_o, bank_o, restore_en_o} & 17'h1FFFF, 17'h0);
        chk("R1", {16'd0, restore_en_o}, 17'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: fast return before any capture gives zeros
        step(1'b0, 1'b0, 1'b1, "R1");
        // R2: vector capture
        live(17'h1A5C3);
        step(1'b1, 1'b0, 1'b0, "R2");
        live(17'h00001);
        step(1'b0, 1'b0, 1'b1, "R2");
        // R8: repeated fast returns keep copy
        step(1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, "R8");
        // R5: live changes without strobes, plain return
        live(17'h0F0F0);
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        // R3: fast call capture
        live(17'h15A5A);
        step(1'b0, 1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b1, "R3");
        // R7: nested interrupt overwrites
        live(17'h0AAAA);
        step(1'b1, 1'b0, 1'b0, "R7");
        live(17'h1FFFF);
        step(1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, "R7");
        // R6: capture and restore together
        live(17'h12345);
        step(1'b1, 1'b0, 1'b1, "R6");
        live(17'h06789);
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic v, c, r;
            live(17'($urandom()));
            v = ($urandom() % 6) == 0;
            c = ($urandom() % 6) == 0;
            r = ($urandom() % 3) == 0;
            step(v, c, r, held ? "R7" : "R1");
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule